// File: doc/BRIEF.md
# PHY Configuration Register Bank with Link Wake

This block is the configuration register bank of a serial-bus physical-layer device. It holds fixed capability codes that software can only read. It holds control bits that software can write, and it forms the link-active, contender and power-class bits that go into the node's self-identification packet. It also keeps a small set of sticky event flags, which software clears by writing a 1 to them.

Two resets act on the block. The hardware reset puts every field at its power-up value and loads the power class from strap pins. A bus reset is a single-cycle strobe from the arbitration logic, and it clears only the short-reset request. When the watchdog enable is set and the link layer reports itself inactive, a pending configuration-timeout or cable-power event drives a link-on wake output. That output stays asserted until software clears the flags or the link layer becomes active.

Software reaches the bank through a plain address, write-enable and data port. Reads are combinational from the address. Event inputs are single-cycle strobes synchronous to the clock. The one exception is the cable power status level, which is asynchronous.

Top module: `phy_cfg_regs`

## Requirements
- R1: Address 0 reads 0x73, which is the port count 3 in bits [3:0] and the speed code 111b in bits [6:4]. Address 1 reads 0x0F, which is the delay code Fh in bits [3:0] and the jitter code 0 in bits [6:4]. Writes to either address change nothing.
- R2: Control register (address 2) bit 0 is link-control. It is 1 after hardware reset and keeps its value through a bus reset. The output sid_link_active equals link-control AND lps.
- R3: Control bit 1 is contender. It is 0 after hardware reset, only a software write can set it, and it keeps its value through a bus reset. It is copied to sid_contender.
- R4: Control bits [4:2] are the power class. They load from pwr_strap on hardware reset, software can write them, and they keep their value through a bus reset. They are copied to sid_pwr_class.
- R5: Control bit 7 is the short-reset request, brought out on short_reset_req. It is 0 after hardware reset and software can write it. A bus reset clears it, and the bus reset wins over a write in the same cycle.
- R6: Interrupt register (address 3) bit 0 is the configuration-timeout flag. It is 0 after hardware reset and is set by cfg_timeout_evt. Writing 1 clears it and writing 0 has no effect. A set wins over a clear in the same cycle.
- R7: Interrupt bit 1 is the cable-power flag. It is 1 after hardware reset and is cleared by writing 1. It is set by a high-to-low transition of cps_in, detected after a two-flop synchronizer. A low level held steady or a rising edge does not set it again.
- R8: Interrupt bit 2 is the state-timeout flag. It is 0 after hardware reset, is set by state_timeout_evt, and is cleared by writing 1.
- R9: Interrupt bit 3 is the port-event flag. It is 0 after hardware reset and is cleared by writing 1. It sets only while the watchdog enable is 1, on either of two causes: a resume_evt strobe on any port, or one of interrupt bits 0 to 2 being set while lps is 0.
- R10: link_on equals watchdog enable AND NOT lps AND (configuration-timeout flag OR cable-power flag). The state-timeout flag does not drive it.
- R11: Control bit 5 is standby enable and control bit 6 is watchdog enable. Both are 0 after hardware reset, software can write both, and both keep their value through a bus reset. Standby enable is brought out on standby_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| pwr_strap | input | 3 | Power-class strap value loaded at hardware reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| bus_reset | input | 1 | Bus reset strobe |
| lps | input | 1 | Link layer active status |
| cps_in | input | 1 | Cable power status, asynchronous |
| cfg_timeout_evt | input | 1 | Configuration timeout strobe |
| state_timeout_evt | input | 1 | State timeout strobe |
| resume_evt | input | 3 | Per-port resume start strobes |
| sid_link_active | output | 1 | Link-active bit for self-ID |
| sid_contender | output | 1 | Contender bit for self-ID |
| sid_pwr_class | output | 3 | Power class for self-ID |
| short_reset_req | output | 1 | Short arbitrated bus reset request |
| standby_en | output | 1 | Standby/restore enable for all ports |
| link_on | output | 1 | Wake request to the link layer |

## Verification
The assertions check four things on every cycle. A sticky flag holds its value unless it is set or cleared, and a set always lands. The contender bit rises only after a control write. A bus reset leaves link-control untouched and always drops the short-reset request. A detected cable-power fall or a watchdog-enabled resume reaches its flag one cycle later. Only the bench scenarios can show the rest: the power class loaded from each strap value, each field's value after a hardware reset compared with after a bus reset, and the cycle on which the synchronized cable-power edge arrives. They also show that a low cps_in held steady does not set the flag again, and the full truth table of link_on over the watchdog enable, lps and the two flags that drive it.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CAP0 = 2'd0,
      SEL_CAP1 = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_IRQ  = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int CB_LCTL = 0;
   localparam int CB_CONT = 1;
   localparam int CB_PWR  = 2;
   localparam int CB_SBY  = 5;
   localparam int CB_WDOG = 6;
   localparam int CB_SRR  = 7;

   // interrupt register bit positions
   localparam int IB_CTO  = 0;
   localparam int IB_CPS  = 1;
   localparam int IB_STO  = 2;
   localparam int IB_PEV  = 3;
   localparam int NUM_FLAGS = 4;
   localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b0010;
endpackage

// File: rtl/phy_cfg_sync.sv
module phy_cfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("phy_cfg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/phy_cfg_w1c.sv
module phy_cfg_w1c #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RST_VAL;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(q)); // R6
   AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q); // R6
endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
   import phy_cfg_pkg::*;
#(
   parameter int          NUM_PORTS   = 3,
   parameter int          PORT_CNT_W  = 4,
   parameter int          SPEED_W     = 3,
   parameter int          DELAY_W     = 4,
   parameter int          JITTER_W    = 3,
   parameter int          PWR_W       = 3,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [2:0]  SPEED_CODE  = 3'b111,
   parameter logic [3:0]  DELAY_CODE  = 4'hF,
   parameter logic [2:0]  JITTER_CODE = 3'h0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PWR_W-1:0]     pwr_strap,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 bus_reset,
   input  logic                 lps,
   input  logic                 cps_in,
   input  logic                 cfg_timeout_evt,
   input  logic                 state_timeout_evt,
   input  logic [NUM_PORTS-1:0] resume_evt,
   output logic                 sid_link_active,
   output logic                 sid_contender,
   output logic [PWR_W-1:0]     sid_pwr_class,
   output logic                 short_reset_req,
   output logic                 standby_en,
   output logic                 link_on
);
   localparam logic [PORT_CNT_W-1:0] PORTS_CODE = PORT_CNT_W'(NUM_PORTS);

   generate
      if (NUM_PORTS >= (1 << PORT_CNT_W)) begin : g_bad_ports
         $error("phy_cfg_regs: NUM_PORTS does not fit PORT_CNT_W");
      end
      if (DATA_W < 8 || PORT_CNT_W + SPEED_W > DATA_W || DELAY_W + JITTER_W > DATA_W) begin : g_bad_width
         $error("phy_cfg_regs: DATA_W too narrow for field layout");
      end
      if (PWR_W != 3 || SPEED_W != 3 || DELAY_W != 4 || JITTER_W != 3) begin : g_bad_field
         $error("phy_cfg_regs: field widths must match the control layout");
      end
   endgenerate

   logic wr_ctrl, wr_irq;
   assign wr_ctrl = wr_en && (reg_sel_e'(addr) == SEL_CTRL);
   assign wr_irq  = wr_en && (reg_sel_e'(addr) == SEL_IRQ);

   // control bits
   logic             lctl_q, cont_q, sby_q, wdog_q, srr_q;
   logic [PWR_W-1:0] pwr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lctl_q <= 1'b1;
         cont_q <= 1'b0;
         pwr_q  <= pwr_strap;
         sby_q  <= 1'b0;
         wdog_q <= 1'b0;
         srr_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            lctl_q <= wdata[CB_LCTL];
            cont_q <= wdata[CB_CONT];
            pwr_q  <= wdata[CB_PWR +: PWR_W];
            sby_q  <= wdata[CB_SBY];
            wdog_q <= wdata[CB_WDOG];
            srr_q  <= wdata[CB_SRR];
         end
         if (bus_reset) srr_q <= 1'b0;
      end
   end

   // cable power edge
   logic cps_fall;
   phy_cfg_sync #(.STAGES(SYNC_STAGES)) u_cps_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cps_in), .fall(cps_fall));

   // sticky flags
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
   logic                 pev_cause;

   assign pev_cause = (|resume_evt) ||
                      ((flag_q[IB_CTO] | flag_q[IB_CPS] | flag_q[IB_STO]) && !lps);

   always_comb begin
      flag_set         = '0;
      flag_set[IB_CTO] = cfg_timeout_evt;
      flag_set[IB_CPS] = cps_fall;
      flag_set[IB_STO] = state_timeout_evt;
      flag_set[IB_PEV] = wdog_q && pev_cause;
      flag_clr         = wr_irq ? wdata[NUM_FLAGS-1:0] : '0;
   end

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         phy_cfg_w1c #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk(clk), .rst_n(rst_n), .set(flag_set[i]),
            .clr(flag_clr[i]), .q(flag_q[i]));
      end
   endgenerate

   // read mux
   always_comb begin
      rdata = '0;
      case (reg_sel_e'(addr))
         SEL_CAP0: begin
            rdata[PORT_CNT_W-1:0]               = PORTS_CODE;
            rdata[PORT_CNT_W +: SPEED_W]        = SPEED_CODE;
         end
         SEL_CAP1: begin
            rdata[DELAY_W-1:0]                  = DELAY_CODE;
            rdata[DELAY_W +: JITTER_W]          = JITTER_CODE;
         end
         SEL_CTRL: begin
            rdata[CB_LCTL]          = lctl_q;
            rdata[CB_CONT]          = cont_q;
            rdata[CB_PWR +: PWR_W]  = pwr_q;
            rdata[CB_SBY]           = sby_q;
            rdata[CB_WDOG]          = wdog_q;
            rdata[CB_SRR]           = srr_q;
         end
         default: rdata[NUM_FLAGS-1:0] = flag_q;
      endcase
   end

   assign sid_link_active = lctl_q & lps;
   assign sid_contender   = cont_q;
   assign sid_pwr_class   = pwr_q;
   assign short_reset_req = srr_q;
   assign standby_en      = sby_q;
   assign link_on         = wdog_q && !lps && (flag_q[IB_CTO] || flag_q[IB_CPS]);

   AST_SRR_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !short_reset_req); // R5
   AST_LCTL_BUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_reset && !wr_ctrl) |=> $stable(lctl_q)); // R2
   AST_CONT_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cont_q) |-> $past(wr_ctrl)); // R3
   AST_CPS_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cps_fall |=> flag_q[IB_CPS]); // R7
   AST_PEV_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (wdog_q && (|resume_evt)) |=> flag_q[IB_PEV]); // R9
endmodule

// File: tb/phy_cfg_regs_test.sv
`timescale 1ns/1ps
module phy_cfg_regs_test;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [2:0] pwr_strap = 0;
   logic [1:0] addr = 0;
   logic       wr_en = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic       bus_reset = 0, lps = 1, cps_in = 1;
   logic       cfg_timeout_evt = 0, state_timeout_evt = 0;
   logic [2:0] resume_evt = 0;
   logic       sid_link_active, sid_contender, short_reset_req, standby_en, link_on;
   logic [2:0] sid_pwr_class;

   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   phy_cfg_regs uut (
      .clk(clk), .rst_n(rst_n), .pwr_strap(pwr_strap), .addr(addr),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .bus_reset(bus_reset),
      .lps(lps), .cps_in(cps_in), .cfg_timeout_evt(cfg_timeout_evt),
      .state_timeout_evt(state_timeout_evt), .resume_evt(resume_evt),
      .sid_link_active(sid_link_active), .sid_contender(sid_contender),
      .sid_pwr_class(sid_pwr_class), .short_reset_req(short_reset_req),
      .standby_en(standby_en), .link_on(link_on));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic hw_reset(input logic [2:0] s);
      @(negedge clk);
      rst_n = 0; pwr_strap = s; lps = 1; cps_in = 1; wr_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
      @(negedge clk);
      addr = a;
      #1 chk(tag, rdata, exp);
   endtask

   task automatic pulse_bus;
      @(negedge clk); bus_reset = 1;
      @(negedge clk); bus_reset = 0;
   endtask

   task automatic pulse_cto;
      @(negedge clk); cfg_timeout_evt = 1;
      @(negedge clk); cfg_timeout_evt = 0;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=00 expected=01");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: fixed capability codes, writes ignored
      hw_reset(3'd0);
      rd("R1 cap0", 2'd0, 8'h73);
      rd("R1 cap1", 2'd1, 8'h0F);
      wr(2'd0, 8'hFF); wr(2'd1, 8'hA5);
      rd("R1 cap0 after write", 2'd0, 8'h73);
      rd("R1 cap1 after write", 2'd1, 8'h0F);

      // hardware reset values across all strap values (R2 R3 R4 R5 R11, flags R6 R7 R8 R9)
      for (int s = 0; s < 8; s++) begin
         hw_reset(3'(s));
         rd("R4 ctrl hw reset", 2'd2, 8'((s << 2) | 1));
         chk("R4 sid_pwr_class", {5'd0, sid_pwr_class}, 8'(s));
         chk("R3 sid_contender reset", {7'd0, sid_contender}, 8'h00);
         chk("R5 srr reset", {7'd0, short_reset_req}, 8'h00);
         chk("R11 standby reset", {7'd0, standby_en}, 8'h00);
         rd("R7 irq hw reset", 2'd3, 8'h02);
      end

      // bus reset keeps all but short reset request
      hw_reset(3'd5);
      wr(2'd3, 8'h02);
      lps = 1;
      wr(2'd2, 8'hEE);  // srr=1 wdog=1 sby=1 pwr=011 cont=1 lctl=0
      chk("R5 srr set by write", {7'd0, short_reset_req}, 8'h01);
      chk("R3 contender by write", {7'd0, sid_contender}, 8'h01);
      pulse_bus();
      rd("R2 R3 R4 R11 ctrl after bus reset", 2'd2, 8'h6E);
      chk("R5 srr after bus reset", {7'd0, short_reset_req}, 8'h00);
      chk("R4 pwr after bus reset", {5'd0, sid_pwr_class}, 8'h03);
      chk("R11 standby after bus reset", {7'd0, standby_en}, 8'h01);
      wr(2'd2, 8'h01);
      pulse_bus();
      rd("R2 lctl kept by bus reset", 2'd2, 8'h01);

      // R5: bus reset wins over same-cycle write
      @(negedge clk);
      addr = 2'd2; wdata = 8'h81; wr_en = 1; bus_reset = 1;
      @(negedge clk);
      wr_en = 0; bus_reset = 0;
      chk("R5 bus reset beats write", {7'd0, short_reset_req}, 8'h00);

      // R2: link-active = lctl AND lps
      for (int k = 0; k < 4; k++) begin
         wr(2'd2, 8'(k & 1));
         lps = k[1];
         @(negedge clk);
         chk("R2 sid_link_active", {7'd0, sid_link_active}, 8'((k & 1) & (k >> 1)));
      end
      lps = 1;

      // R6: configuration timeout flag
      hw_reset(3'd0);
      wr(2'd3, 8'h02);
      rd("R7 cps flag cleared", 2'd3, 8'h00);
      pulse_cto();
      rd("R6 cto set", 2'd3, 8'h01);
      wr(2'd3, 8'h00);
      rd("R6 write 0 no effect", 2'd3, 8'h01);
      wr(2'd3, 8'h01);
      rd("R6 write 1 clears", 2'd3, 8'h00);
      @(negedge clk);
      cfg_timeout_evt = 1; addr = 2'd3; wdata = 8'h01; wr_en = 1;
      @(negedge clk);
      cfg_timeout_evt = 0; wr_en = 0;
      rd("R6 set beats clear", 2'd3, 8'h01);
      wr(2'd3, 8'h01);

      // R8: state timeout flag
      @(negedge clk); state_timeout_evt = 1;
      @(negedge clk); state_timeout_evt = 0;
      rd("R8 sto set", 2'd3, 8'h04);
      wr(2'd3, 8'h0B);
      rd("R8 other clears leave sto", 2'd3, 8'h04);
      wr(2'd3, 8'h04);
      rd("R8 sto cleared", 2'd3, 8'h00);

      // R7: cable power falling edge through synchronizer
      @(negedge clk); cps_in = 0;
      @(negedge clk);
      rd("R7 no flag before sync delay", 2'd3, 8'h00);
      repeat (4) @(negedge clk);
      rd("R7 fall sets flag", 2'd3, 8'h02);
      wr(2'd3, 8'h02);
      repeat (6) @(negedge clk);
      rd("R7 steady low no reset", 2'd3, 8'h00);
      cps_in = 1;
      repeat (6) @(negedge clk);
      rd("R7 rise no set", 2'd3, 8'h00);

      // R9: port event flag
      for (int p = 0; p < 3; p++) begin
         @(negedge clk); resume_evt = 3'(1 << p);
         @(negedge clk); resume_evt = 0;
         rd("R9 resume with wdog off", 2'd3, 8'h00);
      end
      wr(2'd2, 8'h41);
      for (int p = 0; p < 3; p++) begin
         @(negedge clk); resume_evt = 3'(1 << p);
         @(negedge clk); resume_evt = 0;
         rd("R9 resume with wdog on", 2'd3, 8'h08);
         wr(2'd3, 8'h08);
         rd("R9 pev cleared", 2'd3, 8'h00);
      end
      lps = 1;
      @(negedge clk); state_timeout_evt = 1;
      @(negedge clk); state_timeout_evt = 0;
      repeat (2) @(negedge clk);
      rd("R9 flag with link active no pev", 2'd3, 8'h04);
      chk("R10 sto does not drive link_on", {7'd0, link_on}, 8'h00);
      lps = 0;
      repeat (2) @(negedge clk);
      rd("R9 flag with link inactive sets pev", 2'd3, 8'h0C);
      chk("R10 sto alone no link_on", {7'd0, link_on}, 8'h00);

      // R10: link_on truth table
      for (int v = 0; v < 16; v++) begin
         hw_reset(3'd0);
         if (!v[3]) wr(2'd3, 8'h02);
         if (v[2]) pulse_cto();
         wr(2'd2, v[0] ? 8'h41 : 8'h01);
         lps = v[1];
         @(negedge clk);
         #1 chk("R10 link_on", {7'd0, link_on},
                8'(v[0] & ~v[1] & (v[2] | v[3])));
      end
      // R10: stays until flags cleared or link active
      hw_reset(3'd0);
      wr(2'd2, 8'h41);
      lps = 0;
      @(negedge clk);
      chk("R10 link_on asserted", {7'd0, link_on}, 8'h01);
      lps = 1;
      @(negedge clk);
      chk("R10 link active drops link_on", {7'd0, link_on}, 8'h00);
      lps = 0;
      wr(2'd3, 8'h02);
      #1 chk("R10 flag clear drops link_on", {7'd0, link_on}, 8'h00);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule